// File: doc/BRIEF.md
# Four-Way Cache Line Read Sequencer

This block models the read engine of a four-way set-associative second-level cache. A read request carries an address whose low bits pick a set and whose upper bits form the tag. The block looks up all four ways of that set and reads their lines in the same cycle, then keeps only the line of the way that matched. That line goes out as a run of fixed-width beats on a dedicated output bus, in a fixed window that opens five cycles after the request was taken. If no way matches, one miss indication appears in that window instead.

Requests are taken at most once every four cycles. Tag maintenance (filling a way with a new tag and line, or invalidating it) uses the cycles in between. A maintenance write that arrives in the same cycle as an accepted request waits one cycle in a single holding slot. The next lookup of that set then sees the new contents.

The storage is a small register file sized by parameters. Miss handling beyond flagging the miss is left to the surrounding logic.

Top module: `cache_read_seq`

## Requirements
- R1: The request address is 8 bits. Bits [1:0] select one of 4 sets and bits [7:2] are the tag. A lookup hits when some way of that set is valid and holds the same tag. If several ways match, the lowest-numbered way supplies the data.
- R2: After a request is accepted (reqValid and reqAccept high at a clock edge), reqAccept stays low for the next three cycles. No request is taken in that time, even with reqValid held high.
- R3: Once four or more cycles have passed since the last accepted request, reqAccept is high.
- R4: A hit accepted at edge E0 makes outValid and outHit high after edges E0+5 through E0+8. Beat k (k = 0..3) carries bits [72k+71:72k] of the stored 288-bit line, in that order.
- R5: A miss accepted at edge E0 shows outValid=1, outHit=0 and outData=0 for exactly one cycle, after edge E0+5. No data beats follow for that request.
- R6: Requests accepted every four cycles produce output windows that directly follow one another, in request order.
- R7: A maintenance write with tagInval=0 marks the addressed set and way valid and stores tagValue and the 288-bit fillLine there. With tagInval=1 it clears that way's valid bit, and later lookups of that tag miss.
- R8: A maintenance write presented in the same cycle as an accepted request is applied one cycle later, and tagReady is low during that one cycle. The request accepted alongside it sees the old contents. A request accepted afterwards sees the new contents. Maintenance writes are never applied in a request-accept cycle.
- R9: The line is captured when the request is accepted. A fill of the same way after that does not change the beats returned for that request.
- R10: After reset, reqAccept and tagReady are high, outValid is low, and every way is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqAddr | input | 8 | Request address: set in [1:0], tag in [7:2] |
| reqAccept | output | 1 | Request may be taken this cycle |
| tagValid | input | 1 | Maintenance write present |
| tagReady | output | 1 | Maintenance write may be presented |
| tagInval | input | 1 | 1 = invalidate, 0 = fill |
| tagSet | input | 2 | Set addressed by the maintenance write |
| tagWay | input | 2 | Way addressed by the maintenance write |
| tagValue | input | 6 | Tag stored on a fill |
| fillLine | input | 288 | Line stored on a fill, beat 0 in the low bits |
| outValid | output | 1 | Beat or miss indication present |
| outHit | output | 1 | 1 = data beat, 0 = miss indication |
| outData | output | 72 | Beat data, zero on a miss |

## Verification
The bench fills every set and way of the small default configuration with tags and lines derived arithmetically. It then reads all of them back-to-back, interleaved with misses. A design with the wrong beat order, wrong way selection or an off-by-one latency puts the wrong beat at the wrong cycle in at least one of these sixteen windows.

Several corner cases get their own checks:
- A fill issued in the same cycle as a request to the same set. A design that applies it at once makes that request hit, and a design that drops it makes the later request miss.
- A refill of a way just read. A design that reads the line late returns the new data.
- An invalidate. The following lookup of that tag must miss.
- A request held high while the block is blocking requests. A design with the wrong hold-off length either takes it early, which shows as an extra output window, or raises reqAccept late.

// File: rtl/crs_pkg.sv
package crs_pkg;

  // Strobes from the sequencing control into the storage/datapath half.
  typedef struct packed {
    logic acceptReq;     // request taken this cycle: capture lookup result
    logic tagWriteLive;  // apply the maintenance write on the port now
    logic tagWriteHeld;  // apply the maintenance write parked last cycle
    logic tagStash;      // park the maintenance write on the port
    logic moveStage;     // hand captured line to the beat stage
    logic emit;          // drive one beat (or the miss slot) next edge
  } crsStrobes_t;

endpackage

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import crs_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = $clog2(BEATS) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tagValid,
  input  logic        s1Hit,
  output logic        reqAccept,
  output logic        tagReady,
  output logic        outValid,
  output logic        outHit,
  output crsStrobes_t strobes
);

  logic [CNT_W-1:0] coolCnt;
  logic [CNT_W-1:0] s0Age;
  logic [CNT_W-1:0] s1Cnt;
  logic             s0Valid;
  logic             s1Valid;
  logic             tagPending;

  assign reqAccept = (coolCnt == '0);
  assign tagReady  = !tagPending;

  always_comb begin
    strobes              = '0;
    strobes.acceptReq    = reqValid && reqAccept;
    strobes.tagWriteHeld = tagPending;
    strobes.tagWriteLive = tagValid && tagReady && !strobes.acceptReq;
    strobes.tagStash     = tagValid && tagReady && strobes.acceptReq;
    strobes.moveStage    = s0Valid && (s0Age == CNT_W'(BEATS - 1));
    strobes.emit         = s1Valid;
  end

  // Request cadence: one accept, then BEATS-1 blocked cycles.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coolCnt <= '0;
    end else if (strobes.acceptReq) begin
      coolCnt <= CNT_W'(BEATS - 1);
    end else if (coolCnt != '0) begin
      coolCnt <= coolCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagPending <= 1'b0;
    end else begin
      tagPending <= strobes.tagStash;
    end
  end

  // Lookup stage: holds the captured request until its output window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0Valid <= 1'b0;
      s0Age   <= '0;
    end else if (strobes.acceptReq) begin
      s0Valid <= 1'b1;
      s0Age   <= '0;
    end else if (s0Valid) begin
      if (strobes.moveStage) begin
        s0Valid <= 1'b0;
      end else begin
        s0Age <= s0Age + 1'b1;
      end
    end
  end

  // Beat stage: BEATS cycles on a hit, one on a miss.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Cnt   <= '0;
    end else if (strobes.moveStage) begin
      s1Valid <= 1'b1;
      s1Cnt   <= '0;
    end else if (s1Valid) begin
      if (!s1Hit || (s1Cnt == CNT_W'(BEATS - 1))) begin
        s1Valid <= 1'b0;
      end else begin
        s1Cnt <= s1Cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
    end else begin
      outValid <= strobes.emit;
      outHit   <= strobes.emit && s1Hit;
    end
  end

endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int BEAT_W = 72,
  parameter int BEATS  = 4,
  localparam int IDX_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int ADDR_W  = TAG_W + IDX_W,
  localparam int LINE_W  = BEAT_W * BEATS,
  localparam int ENTRIES = SETS * WAYS,
  localparam int ENT_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  crsStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              tagInval,
  input  logic [IDX_W-1:0]  tagSet,
  input  logic [WAY_W-1:0]  tagWay,
  input  logic [TAG_W-1:0]  tagValue,
  input  logic [LINE_W-1:0] fillLine,
  output logic              s1Hit,
  output logic [BEAT_W-1:0] outData
);

  function automatic logic [ENT_W-1:0] entryOf(input logic [IDX_W-1:0] setIdx,
                                               input logic [WAY_W-1:0] wayIdx);
    return ENT_W'(setIdx) * ENT_W'(WAYS) + ENT_W'(wayIdx);
  endfunction

  // Register-file storage.
  logic [TAG_W-1:0]   tagArr  [ENTRIES];
  logic [LINE_W-1:0]  lineArr [ENTRIES];
  logic [ENTRIES-1:0] validArr;

  // Lookup: tag compare and line read of every way in the same cycle.
  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WAYS-1:0]   wayMatch;
  logic [LINE_W-1:0] wayLine [WAYS];
  logic              hitAny;
  logic [LINE_W-1:0] selLine;

  assign reqIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENT_W-1:0] ent;
    assign ent         = entryOf(reqIdx, WAY_W'(w));
    assign wayMatch[w] = validArr[ent] && (tagArr[ent] == reqTag);
    assign wayLine[w]  = lineArr[ent];
  end

  // Lowest matching way wins.
  always_comb begin
    hitAny  = 1'b0;
    selLine = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayMatch[w]) begin
        hitAny  = 1'b1;
        selLine = wayLine[w];
      end
    end
  end

  // Maintenance write: parked copy or live port.
  logic              heldInval;
  logic [IDX_W-1:0]  heldSet;
  logic [WAY_W-1:0]  heldWay;
  logic [TAG_W-1:0]  heldTag;
  logic [LINE_W-1:0] heldLine;

  always_ff @(posedge clk) begin
    if (strobes.tagStash) begin
      heldInval <= tagInval;
      heldSet   <= tagSet;
      heldWay   <= tagWay;
      heldTag   <= tagValue;
      heldLine  <= fillLine;
    end
  end

  logic              wrEn;
  logic              wrInval;
  logic [ENT_W-1:0]  wrEntry;
  logic [TAG_W-1:0]  wrTag;
  logic [LINE_W-1:0] wrLine;

  always_comb begin
    wrEn = strobes.tagWriteLive || strobes.tagWriteHeld;
    if (strobes.tagWriteHeld) begin
      wrInval = heldInval;
      wrEntry = entryOf(heldSet, heldWay);
      wrTag   = heldTag;
      wrLine  = heldLine;
    end else begin
      wrInval = tagInval;
      wrEntry = entryOf(tagSet, tagWay);
      wrTag   = tagValue;
      wrLine  = fillLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
    end else if (wrEn) begin
      validArr[wrEntry] <= !wrInval;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && !wrInval) begin
      tagArr[wrEntry]  <= wrTag;
      lineArr[wrEntry] <= wrLine;
    end
  end

  // Captured line (lookup stage) and shifting beat buffer.
  logic              s0Hit;
  logic [LINE_W-1:0] s0Line;
  logic [LINE_W-1:0] s1Line;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0Hit <= 1'b0;
      s1Hit <= 1'b0;
    end else begin
      if (strobes.acceptReq) s0Hit <= hitAny;
      if (strobes.moveStage) s1Hit <= s0Hit;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.acceptReq) s0Line <= selLine;
    if (strobes.moveStage) begin
      s1Line <= s0Line;
    end else if (strobes.emit) begin
      s1Line <= s1Line >> BEAT_W;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
    end else if (strobes.emit && s1Hit) begin
      outData <= s1Line[BEAT_W-1:0];
    end else begin
      outData <= '0;
    end
  end

endmodule

// File: rtl/cache_read_seq.sv
module cache_read_seq
  import crs_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int BEAT_W = 72,
  parameter int BEATS  = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + IDX_W,
  localparam int LINE_W = BEAT_W * BEATS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqAccept,
  input  logic              tagValid,
  output logic              tagReady,
  input  logic              tagInval,
  input  logic [IDX_W-1:0]  tagSet,
  input  logic [WAY_W-1:0]  tagWay,
  input  logic [TAG_W-1:0]  tagValue,
  input  logic [LINE_W-1:0] fillLine,
  output logic              outValid,
  output logic              outHit,
  output logic [BEAT_W-1:0] outData
);

  crsStrobes_t strobes;
  logic        s1Hit;

  crs_ctrl #(
    .BEATS(BEATS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .tagValid (tagValid),
    .s1Hit    (s1Hit),
    .reqAccept(reqAccept),
    .tagReady (tagReady),
    .outValid (outValid),
    .outHit   (outHit),
    .strobes  (strobes)
  );

  crs_datapath #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .BEAT_W(BEAT_W),
    .BEATS (BEATS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .tagInval(tagInval),
    .tagSet  (tagSet),
    .tagWay  (tagWay),
    .tagValue(tagValue),
    .fillLine(fillLine),
    .s1Hit   (s1Hit),
    .outData (outData)
  );

endmodule

// File: rtl/crs_checker.sv
module crs_checker
  import crs_pkg::*;
#(
  parameter int BEATS = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqAccept,
  input logic        tagReady,
  input logic        outValid,
  input logic        outHit,
  input crsStrobes_t strobes
);

  // Cycles since the last accepted request, saturating at BEATS.
  logic [15:0] sinceAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAcc <= 16'(BEATS);
    end else if (reqValid && reqAccept) begin
      sinceAcc <= 16'd1;
    end else if (sinceAcc < 16'(BEATS)) begin
      sinceAcc <= sinceAcc + 16'd1;
    end
  end

  AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAccept) |-> (sinceAcc >= 16'(BEATS))); // R2

  AST_ACCEPT_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (sinceAcc >= 16'(BEATS)) |-> reqAccept); // R3

  AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHit) |=> !outValid); // R5

  AST_HIT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid && outHit) |=> (outValid && outHit)); // R4

  AST_TAG_INTERLEAVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acceptReq |-> !(strobes.tagWriteLive || strobes.tagWriteHeld)); // R8

  AST_TAG_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    !tagReady |=> tagReady); // R8

endmodule

bind cache_read_seq crs_checker #(.BEATS(BEATS)) u_check (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqAccept(reqAccept),
  .tagReady (tagReady),
  .outValid (outValid),
  .outHit   (outHit),
  .strobes  (strobes)
);

// File: tb/cache_read_seq_bench.sv
module cache_read_seq_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [7:0]   reqAddr = '0;
  logic         reqAccept;
  logic         tagValid = 1'b0;
  logic         tagReady;
  logic         tagInval = 1'b0;
  logic [1:0]   tagSet = '0;
  logic [1:0]   tagWay = '0;
  logic [5:0]   tagValue = '0;
  logic [287:0] fillLine = '0;
  logic         outValid;
  logic         outHit;
  logic [71:0]  outData;

  always #4 clk = ~clk;

  cache_read_seq u_cache_read_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqAccept(reqAccept), .tagValid(tagValid), .tagReady(tagReady),
    .tagInval(tagInval), .tagSet(tagSet), .tagWay(tagWay),
    .tagValue(tagValue), .fillLine(fillLine), .outValid(outValid),
    .outHit(outHit), .outData(outData)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit monOn   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side model of the storage.
  bit           mValid [16];
  logic [5:0]   mTag   [16];
  logic [287:0] mLine  [16];

  // Expected output per cycle (ring indexed by edge count).
  bit          expV [16];
  bit          expH [16];
  logic [71:0] expD [16];
  string       expR [16];

  task automatic chk(input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [287:0] makeLine(input int s, input int w, input int salt);
    logic [287:0] l;
    for (int b = 0; b < 4; b++)
      l[b*72 +: 72] = {8'(s), 8'(w), 8'(b), 8'(salt),
                       40'(s * 4099 + w * 257 + b * 31 + salt * 7 + 1)};
    return l;
  endfunction

  function automatic logic [5:0] tagOf(input int s, input int w);
    return 6'((s * 3 + w * 11 + 2) % 64);
  endfunction

  task automatic modelLookup(input logic [7:0] addr, output bit hit,
                             output logic [287:0] line);
    hit  = 1'b0;
    line = '0;
    for (int w = 3; w >= 0; w--) begin
      int e;
      e = int'(addr[1:0]) * 4 + w;
      if (mValid[e] && mTag[e] == addr[7:2]) begin
        hit  = 1'b1;
        line = mLine[e];
      end
    end
  endtask

  task automatic modelWrite(input bit inval, input int s, input int w,
                            input logic [5:0] t, input logic [287:0] l);
    mValid[s*4+w] = !inval;
    if (!inval) begin
      mTag[s*4+w]  = t;
      mLine[s*4+w] = l;
    end
  endtask

  // Schedule expectations for a request accepted at edge e0.
  task automatic expectFor(input logic [7:0] addr, input int e0, input string req);
    bit hit;
    logic [287:0] line;
    modelLookup(addr, hit, line);
    for (int b = 0; b < 4; b++) begin
      int sl;
      sl = (e0 + 5 + b) % 16;
      expR[sl] = req;
      if (hit) begin
        expV[sl] = 1'b1; expH[sl] = 1'b1; expD[sl] = line[b*72 +: 72];
      end else if (b == 0) begin
        expV[sl] = 1'b1; expH[sl] = 1'b0; expD[sl] = '0;
      end
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic request(input logic [7:0] addr, input string req);
    while (!reqAccept) @(negedge clk);
    expectFor(addr, cyc + 1, req);
    reqValid = 1'b1;
    reqAddr  = addr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tagOp(input bit inval, input int s, input int w,
                       input logic [5:0] t, input logic [287:0] l);
    tagValid = 1'b1; tagInval = inval; tagSet = 2'(s); tagWay = 2'(w);
    tagValue = t; fillLine = l;
    @(negedge clk);
    tagValid = 1'b0;
    modelWrite(inval, s, w, t, l);
  endtask

  // Output monitor: compares every cycle against the schedule.
  always @(negedge clk) begin
    if (monOn) begin
      int sl;
      sl = cyc % 16;
      chk(expV[sl] ? expR[sl] : "R6", "outValid", 72'(outValid), 72'(expV[sl]));
      if (expV[sl]) begin
        chk(expR[sl], "outHit", 72'(outHit), 72'(expH[sl]));
        chk(expR[sl], "outData", outData, expD[sl]);
      end
      expV[sl] = 1'b0;
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual cycle %0d expected below 50000", cyc);
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 1'b0; expV[i] = 1'b0; expR[i] = "R4";
    end
    repeat (3) @(negedge clk);
    rstN  = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    chk("R10", "reqAccept", 72'(reqAccept), 72'd1);
    chk("R10", "tagReady", 72'(tagReady), 72'd1);
    chk("R10", "outValid", 72'(outValid), 72'd0);
    for (int s = 0; s < 4; s++) request({6'(s * 7 + 1), 2'(s)}, "R10");

    // R7: fill every set and way
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        tagOp(1'b0, s, w, tagOf(s, w), makeLine(s, w, 0));

    // R1 R4 R6: back-to-back hits across all sets and ways
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        request({tagOf(s, w), 2'(s)}, "R4");
    // R5: misses mixed with hits
    for (int s = 0; s < 4; s++) begin
      request({6'd63, 2'(s)}, "R5");
      request({tagOf(s, 3 - s), 2'(s)}, "R6");
    end

    // R1: duplicate tag in ways 1 and 3 of set 1, lowest way supplies data
    tagOp(1'b0, 1, 3, tagOf(1, 1), makeLine(1, 3, 5));
    request({tagOf(1, 1), 2'd1}, "R1");

    // R7: invalidate way 1 of set 2
    tagOp(1'b1, 2, 1, '0, '0);
    request({tagOf(2, 1), 2'd2}, "R7");
    request({tagOf(2, 2), 2'd2}, "R7");

    // R8: fill in the same cycle as a request to the same set
    while (!reqAccept) @(negedge clk);
    expectFor({6'd50, 2'd3}, cyc + 1, "R8");
    reqValid = 1'b1; reqAddr = {6'd50, 2'd3};
    tagValid = 1'b1; tagInval = 1'b0; tagSet = 2'd3; tagWay = 2'd2;
    tagValue = 6'd50; fillLine = makeLine(3, 2, 9);
    @(negedge clk);
    reqValid = 1'b0; tagValid = 1'b0;
    chk("R8", "tagReady deferred", 72'(tagReady), 72'd0);
    modelWrite(1'b0, 3, 2, 6'd50, makeLine(3, 2, 9));
    @(negedge clk);
    chk("R8", "tagReady restored", 72'(tagReady), 72'd1);
    request({6'd50, 2'd3}, "R8");

    // R9: refill of a way right after it was read
    request({tagOf(0, 2), 2'd0}, "R9");
    tagOp(1'b0, 0, 2, tagOf(0, 2), makeLine(0, 2, 11));
    request({tagOf(0, 2), 2'd0}, "R9");

    // R2 R3: request held high during hold-off
    request({tagOf(1, 0), 2'd1}, "R2");
    reqValid = 1'b1; reqAddr = {tagOf(2, 0), 2'd2};
    chk("R2", "reqAccept +1", 72'(reqAccept), 72'd0);
    @(negedge clk);
    chk("R2", "reqAccept +2", 72'(reqAccept), 72'd0);
    @(negedge clk);
    chk("R2", "reqAccept +3", 72'(reqAccept), 72'd0);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R3", "reqAccept +4", 72'(reqAccept), 72'd1);
    repeat (3) @(negedge clk);
    chk("R3", "reqAccept idle", 72'(reqAccept), 72'd1);

    repeat (12) @(negedge clk);
    monOn = 1'b0;
    finishRun();
  end

endmodule